// File: doc/BRIEF.md
# Multi-mode 8-bit timer counter

This block is an up/down counter for a small general-purpose timer. A power-of-two prescaler thins a base tick stream into count enables. The counter then advances in one of four modes. Two modes run up to a fixed top of all ones or to a top value supplied by channel 0's compare register. One mode counts down once from that value, and one goes up to that value and back down. Capture/compare channels sit outside the block and consume its count, its direction, its zero flag, its overflow event and a one-cycle pulse that re-initializes their output pins.

Software sees a single control word. A write sets the divider code, the run bit, the overflow interrupt mask and the mode. In the same write it can also fire a one-shot clear strobe. The clear strobe zeroes the count, restarts the prescaler and pulses the channel re-initialization line. It never reads back as 1.

Top module: `tmr8_top`

## Requirements
- R1: After reset the count is 0x00, the zero flag is 1, the interrupt request and channel-init pulse are 0, and the control readback is 0x10. The readback layout is div code in bits [2:0], run in bit 3, overflow mask in bit 4, clear in bit 5 and mode in bits [7:6].
- R2: With divider code N and run set, the count advances once per 2^N asserted base ticks (N=0 gives /1, N=7 gives /128). Cycles without a base tick do not advance it.
- R3: While the registered run bit is 0 the count holds its value.
- R4: A control write with bit 5 set forces the count to 0x00 and clears the direction flag in that clock edge. It pulses chan_init for exactly the next cycle and restarts the prescaler, so the first enable comes 2^N base ticks later. Bit 5 reads back as 0.
- R5: Mode 00 counts 0x00 to 0xFF and wraps to 0x00, and the step onto 0x00 raises ovf_pulse for one cycle.
- R6: Mode 10 counts 0x00 up to cmp_top and then wraps to 0x00, and the step onto 0x00 raises ovf_pulse.
- R7: In mode 01 a control write that takes run from 0 to 1 loads cmp_top. The count then steps down by one per enable, raises ovf_pulse on the step onto 0x00, and stays at 0x00 afterwards. dir_down reads 1 in this mode.
- R8: Mode 11 counts 0x00 up to cmp_top and then down to 0x00 and repeats. dir_down is 1 while descending, and ovf_pulse rises on each step onto 0x00.
- R9: irq equals ovf_pulse gated by the overflow mask bit, and cnt_zero is 1 exactly when the count is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base tick enable feeding the prescaler |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| cmp_top | input | 8 | Channel-0 compare value used as top or reload value |
| ctl_rdata | output | 8 | Control word readback (clear bit reads 0) |
| count | output | 8 | Live count |
| dir_down | output | 1 | 1 while the counter is counting down |
| cnt_zero | output | 1 | Count equals 0x00 |
| ovf_pulse | output | 1 | One-cycle overflow event |
| irq | output | 1 | Masked overflow interrupt request |
| chan_init | output | 1 | One-cycle pulse that re-initializes channel outputs |

## Verification
The bench builds the block with its default 8-bit count and 3-bit divider code. A full mode-00 wrap therefore takes 256 enables, and the slowest divider code 7 spreads two steps across 256 base ticks, both short enough to watch every cycle. Small compare values of 3 to 5 bring the wrap of mode 10, the park at zero in mode 01 and the turnaround of mode 11 within a few cycles. In mode 01 the overflow is seen both with the mask set and with it cleared.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_WRAP = 2'b10,
        MODE_UPDN = 2'b11
    } cnt_mode_e;

endpackage

// File: rtl/tmr8_ctl_regs.sv
module tmr8_ctl_regs
    import tmr8_pkg::*;
#(
    parameter int DIV_W = 3,
    localparam int CTL_W = DIV_W + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [DIV_W-1:0] div_code,
    output logic             run_q,
    output logic             ovf_mask,
    output cnt_mode_e        mode,
    output logic             clr_now,
    output logic             reload_now,
    output logic             chan_init,
    output logic [CTL_W-1:0] ctl_rdata
);

    localparam int RUN_B  = DIV_W;
    localparam int MASK_B = DIV_W + 1;
    localparam int CLR_B  = DIV_W + 2;
    localparam int MODE_L = DIV_W + 3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             run;
        logic             mask;
        cnt_mode_e        mode;
        logic             init;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    cnt_mode_e wr_mode;

    always_comb begin
        wr_mode    = cnt_mode_e'(ctl_wdata[MODE_L+1:MODE_L]);
        clr_now    = ctl_we & ctl_wdata[CLR_B];
        reload_now = ctl_we & ctl_wdata[RUN_B] & ~st_q.run & (wr_mode == MODE_DOWN);
        st_d       = st_q;
        st_d.init  = clr_now;
        if (ctl_we) begin
            st_d.div  = ctl_wdata[DIV_W-1:0];
            st_d.run  = ctl_wdata[RUN_B];
            st_d.mask = ctl_wdata[MASK_B];
            st_d.mode = wr_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{div: '0, run: 1'b0, mask: 1'b1, mode: MODE_FREE, init: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_code  = st_q.div;
    assign run_q     = st_q.run;
    assign ovf_mask  = st_q.mask;
    assign mode      = st_q.mode;
    assign chan_init = st_q.init;
    assign ctl_rdata = {st_q.mode, 1'b0, st_q.mask, st_q.run, st_q.div};

    // R4: a clear strobe is followed by exactly one cycle of channel re-init
    a_r4_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[CLR_B]) |=> chan_init);
    a_r4_init_single: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_init && !clr_now) |=> !chan_init);

endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
    parameter int DIV_W = 3,
    localparam int PRE_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick_en
);

    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] pmask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            pmask[i] = (div_code > i[DIV_W-1:0]);
        end
    end

    always_comb begin
        st_d    = st_q;
        tick_en = 1'b0;
        if (clr) begin
            st_d.pcnt = '0;
        end else if (run && base_tick) begin
            tick_en   = ((st_q.pcnt & pmask) == pmask);
            st_d.pcnt = st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: no enable without a base tick while running
    a_r2_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |-> (base_tick && run && !clr));

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clr,
    input  logic             reload,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             cnt_zero,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (reload) begin
            st_d.cnt  = top;
            st_d.down = 1'b0;
        end else if (step) begin
            unique case (mode)
                MODE_FREE: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.ovf = (st_q.cnt == CNT_MAX);
                end
                MODE_WRAP: begin
                    if (st_q.cnt >= top) begin
                        st_d.cnt = '0;
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                MODE_DOWN: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - 1'b1;
                        st_d.ovf = (st_q.cnt == CNT_ONE);
                    end
                end
                MODE_UPDN: begin
                    if (st_q.down) begin
                        if (st_q.cnt <= CNT_ONE) begin
                            st_d.cnt  = '0;
                            st_d.down = 1'b0;
                            st_d.ovf  = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end else if (st_q.cnt >= top) begin
                        if (top == '0) begin
                            st_d.cnt = '0;
                            st_d.ovf = 1'b1;
                        end else begin
                            st_d.cnt  = st_q.cnt - 1'b1;
                            st_d.down = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign dir_down = (mode == MODE_DOWN) | st_q.down;
    assign cnt_zero = (st_q.cnt == '0);
    assign ovf      = st_q.ovf;

    // R5: every overflow event lands the count on zero
    a_r5_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));
    // R3: without a step, clear or reload the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr && !reload) |=> (count == $past(count)));
    // R4: clear zeroes the count and direction
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !st_q.down));
    // R7: single-shot down count parks at zero
    a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN && count == '0 && !clr && !reload) |=> (count == '0 && !ovf));

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 3,
    localparam int CTL_W = DIV_W + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [CNT_W-1:0] cmp_top,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             cnt_zero,
    output logic             ovf_pulse,
    output logic             irq,
    output logic             chan_init
);

    logic [DIV_W-1:0] div_code;
    logic             run_q;
    logic             ovf_mask;
    cnt_mode_e        mode;
    logic             clr_now;
    logic             reload_now;
    logic             tick_en;

    tmr8_ctl_regs #(.DIV_W(DIV_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .div_code   (div_code),
        .run_q      (run_q),
        .ovf_mask   (ovf_mask),
        .mode       (mode),
        .clr_now    (clr_now),
        .reload_now (reload_now),
        .chan_init  (chan_init),
        .ctl_rdata  (ctl_rdata)
    );

    tmr8_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .run       (run_q),
        .clr       (clr_now),
        .div_code  (div_code),
        .tick_en   (tick_en)
    );

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_en),
        .clr      (clr_now),
        .reload   (reload_now),
        .mode     (mode),
        .top      (cmp_top),
        .count    (count),
        .dir_down (dir_down),
        .cnt_zero (cnt_zero),
        .ovf      (ovf_pulse)
    );

    assign irq = ovf_pulse & ovf_mask;

    // R9: an interrupt request never appears without an overflow event
    a_r9_irq_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_pulse);

endmodule

// File: tb/tmr8_top_tb.sv
module tmr8_top_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] cmp_top = '0;
    logic [7:0] ctl_rdata;
    logic [7:0] count;
    logic       dir_down, cnt_zero, ovf_pulse, irq, chan_init;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] cnt;
        logic       ovf;
        logic       irq;
        logic       dir;
        logic       chan;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr8_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .cmp_top   (cmp_top),
        .ctl_rdata (ctl_rdata),
        .count     (count),
        .dir_down  (dir_down),
        .cnt_zero  (cnt_zero),
        .ovf_pulse (ovf_pulse),
        .irq       (irq),
        .chan_init (chan_init)
    );

    function automatic logic [7:0] cw(input logic [2:0] dv, input logic rn,
                                      input logic mk, input logic cl, input logic [1:0] md);
        return {md, cl, mk, rn, dv};
    endfunction

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor: pops one expected item per cycle and compares the outputs
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(count == it.cnt && ovf_pulse == it.ovf && irq == it.irq &&
                  dir_down == it.dir && chan_init == it.chan && cnt_zero == (it.cnt == 8'h00),
                  it.tag,
                  $sformatf("actual cnt=%02h ovf=%0b irq=%0b dir=%0b init=%0b zero=%0b expected cnt=%02h ovf=%0b irq=%0b dir=%0b init=%0b zero=%0b",
                            count, ovf_pulse, irq, dir_down, chan_init, cnt_zero,
                            it.cnt, it.ovf, it.irq, it.dir, it.chan, (it.cnt == 8'h00)));
        end
    end

    // driver: sets the inputs for one clock edge and queues the expected result
    task automatic cyc(input logic we, input logic [7:0] wd, input logic tk, input logic [7:0] ecnt,
                       input logic eovf, input logic eirq, input logic edir, input logic echan,
                       input string tag);
        item_t it;
        @(negedge clk);
        #1;
        ctl_we    = we;
        ctl_wdata = wd;
        base_tick = tk;
        it.cnt = ecnt; it.ovf = eovf; it.irq = eirq; it.dir = edir; it.chan = echan; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(count == 8'h00 && cnt_zero && !irq && !chan_init && !ovf_pulse, "R1",
              $sformatf("actual cnt=%02h zero=%0b irq=%0b init=%0b expected 00 1 0 0",
                        count, cnt_zero, irq, chan_init));
        check(ctl_rdata == 8'h10, "R1",
              $sformatf("actual rdata=%02h expected 10", ctl_rdata));

        // R5 free-running wrap, R9 interrupt with mask set
        cyc(1, cw(0, 1, 1, 0, 2'b00), 1, 8'h00, 0, 0, 0, 0, "R5");
        for (int k = 1; k <= 257; k++) begin
            cyc(0, 8'h00, 1, 8'(k % 256), (k == 256), (k == 256), 0, 0, (k == 256) ? "R9" : "R5");
        end

        // R3 hold while stopped (the write edge still steps with the old run bit)
        cyc(1, cw(0, 0, 1, 0, 2'b00), 1, 8'h02, 0, 0, 0, 0, "R3");
        for (int k = 0; k < 5; k++) cyc(0, 8'h00, 1, 8'h02, 0, 0, 0, 0, "R3");

        // R4 clear strobe
        cyc(1, cw(0, 0, 1, 1, 2'b00), 1, 8'h00, 0, 0, 0, 1, "R4");
        cyc(0, 8'h00, 1, 8'h00, 0, 0, 0, 0, "R4");
        @(negedge clk);
        check(ctl_rdata == cw(0, 0, 1, 0, 2'b00), "R4",
              $sformatf("actual rdata=%02h expected %02h", ctl_rdata, cw(0, 0, 1, 0, 2'b00)));

        // R2 divide by 4 after a clear, then gated base ticks
        cyc(1, cw(2, 1, 1, 1, 2'b00), 1, 8'h00, 0, 0, 0, 1, "R2");
        for (int k = 1; k <= 12; k++) cyc(0, 8'h00, 1, 8'(k / 4), 0, 0, 0, 0, "R2");
        for (int k = 0; k < 4; k++) cyc(0, 8'h00, 0, 8'h03, 0, 0, 0, 0, "R2");
        // R2 divide by 128
        cyc(1, cw(7, 1, 1, 1, 2'b00), 1, 8'h00, 0, 0, 0, 1, "R2");
        for (int k = 1; k <= 256; k++) cyc(0, 8'h00, 1, 8'(k / 128), 0, 0, 0, 0, "R2");

        // R6 modulo to compare value 5
        cmp_top = 8'd5;
        cyc(1, cw(0, 1, 1, 1, 2'b10), 1, 8'h00, 0, 0, 0, 1, "R6");
        for (int k = 1; k <= 14; k++)
            cyc(0, 8'h00, 1, 8'(k % 6), (k % 6 == 0), (k % 6 == 0), 0, 0, "R6");

        // R7 single down count from 4
        cmp_top = 8'd4;
        cyc(1, cw(0, 0, 1, 1, 2'b01), 1, 8'h00, 0, 0, 1, 1, "R7");
        cyc(1, cw(0, 1, 1, 0, 2'b01), 1, 8'h04, 0, 0, 1, 0, "R7");
        for (int k = 1; k <= 6; k++)
            cyc(0, 8'h00, 1, (k < 4) ? 8'(4 - k) : 8'h00, (k == 4), (k == 4), 1, 0, "R7");
        // R9 same count with the mask cleared: overflow without interrupt
        cyc(1, cw(0, 0, 0, 0, 2'b01), 1, 8'h00, 0, 0, 1, 0, "R9");
        cyc(1, cw(0, 1, 0, 0, 2'b01), 1, 8'h04, 0, 0, 1, 0, "R7");
        for (int k = 1; k <= 5; k++)
            cyc(0, 8'h00, 1, (k < 4) ? 8'(4 - k) : 8'h00, (k == 4), 0, 1, 0, "R9");

        // R8 up/down to 3
        cmp_top = 8'd3;
        cyc(1, cw(0, 1, 1, 1, 2'b11), 1, 8'h00, 0, 0, 0, 1, "R8");
        for (int k = 1; k <= 13; k++) begin
            int p;
            p = k % 6;
            cyc(0, 8'h00, 1, (p <= 3) ? 8'(p) : 8'(6 - p), (p == 0), (p == 0),
                (p == 4 || p == 5), 0, "R8");
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule